// File: doc/BRIEF.md
# Boot ROM Bank Selector with Wait-State Insertion

This block sits on a 20-bit multiplexed-address processor bus in minimum mode and picks one of eight read-only memory devices at the very top of the address space. In its default form the selected window is the top 32 KB. That window is cut into eight 4 KB slices, and each slice drives its own active-low device select. The shared active-low output enable follows the bus read strobe, but only while a device in the window is selected.

The memory devices plus the decode path are slower than the processor's memory access budget. For this reason the block pulls its ready line low for one bus clock in every cycle that hits the window. This inserts one wait state between the second and third bus states. Misses and IO cycles run at full speed.

A parameter widens each slice to 8 KB. With that setting, eight devices cover the top 64 KB. The decoding logic is otherwise the same.

Top module: `rom_bank_sel`

## Requirements
- R1: A memory cycle (`mem_io`=1) whose address has every bit from bit BASE_LSB up to bit 19 set drives exactly one bit of `cs_n` low. BASE_LSB is 15 by default.
- R2: The low bit is `cs_n[k]`, where k is address bits 14..12 by default. Slice k spans F8000h+k·1000h to F8FFFh+k·1000h.
- R3: Any address below the window, for example F7FFFh or 00000h, leaves all `cs_n` bits high.
- R4: An IO cycle (`mem_io`=0) leaves all `cs_n` bits high at every address.
- R5: `oe_n` equals `rd_n` while a select is active. Otherwise `oe_n` is high.
- R6: The bus marks its address state as `bus_phase`=2'b01. When that state hits the window, `rdy` is low for exactly the next clock (the second bus state) and high again in the clock after it.
- R7: A cycle that misses the window, or an IO cycle, never drives `rdy` low.
- R8: While `rst_n` is low and after its release, `rdy` is high until the first hitting cycle.
- R9: With SLICE_AW=13 the window is F0000h to FFFFFh, and address bits 15..13 pick the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Latched bus address |
| mem_io | input | 1 | 1 = memory cycle, 0 = IO cycle |
| rd_n | input | 1 | Active-low read strobe |
| bus_phase | input | 2 | Bus state: 00 idle, 01 address state, 10 second state, 11 later states |
| cs_n | output | NUM_CS | Active-low device selects |
| oe_n | output | 1 | Active-low shared output enable |
| rdy | output | 1 | Ready to processor; low means insert a wait state |

## Verification
Bus cycles are run at both edges of every slice, at the addresses just under the window, at low memory and as IO cycles. This separates the window-edge compare from the slice index and from the memory/IO qualifier. A stepped sweep through the whole address space covers, in the same run, the default instance and a second instance with 8 KB slices. Where the two windows disagree, this exposes any mix-up of the window size. The bench counts the ready-low clocks in each cycle. That count tells one wait state apart from none or two. Cycles with and without a read strobe show whether the output enable follows the strobe or follows the decode alone.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_DATA = 2'b10,
    PH_LATE = 2'b11
  } bus_phase_e;

  // Window test: every address bit from lsb up to aw-1 must be set.
  function automatic logic window_hit(logic [31:0] a, int unsigned lsb, int unsigned aw);
    logic h;
    h = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i >= lsb && i < aw) h = h & a[i];
    end
    return h;
  endfunction

  // Slice number inside the window.
  function automatic int unsigned slice_num(logic [31:0] a, int unsigned slice_aw,
                                            int unsigned cs_w);
    return int'((a >> slice_aw) & ((32'd1 << cs_w) - 32'd1));
  endfunction

endpackage

// File: rtl/rbs_decode.sv
module rbs_decode #(
  parameter int ADDR_W   = 20,
  parameter int SLICE_AW = 12,
  parameter int NUM_CS   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_io,
  output logic [NUM_CS-1:0] cs_n,
  output logic              hit
);
  import rbs_pkg::*;

  localparam int CS_W     = $clog2(NUM_CS);
  localparam int BASE_LSB = SLICE_AW + CS_W;

  logic [CS_W-1:0] sel;

  always_comb begin
    hit = mem_io && window_hit(32'(addr), BASE_LSB, ADDR_W);
    sel = CS_W'(slice_num(32'(addr), SLICE_AW, CS_W));
  end

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    assign cs_n[k] = ~(hit && (sel == CS_W'(k)));
  end

endmodule

// File: rtl/rbs_wait.sv
module rbs_wait #(
  parameter int WAIT_STATES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic rdy
);
  localparam int CNT_W = $clog2(WAIT_STATES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (start)           cnt <= CNT_W'(WAIT_STATES);
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign rdy = (cnt == '0);

endmodule

// File: rtl/rom_bank_sel.sv
module rom_bank_sel #(
  parameter int ADDR_W      = 20,
  parameter int SLICE_AW    = 12,
  parameter int NUM_CS      = 8,
  parameter int WAIT_STATES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_io,
  input  logic              rd_n,
  input  logic [1:0]        bus_phase,
  output logic [NUM_CS-1:0] cs_n,
  output logic              oe_n,
  output logic              rdy
);
  import rbs_pkg::*;

  logic hit;
  logic t1_hit;

  rbs_decode #(.ADDR_W(ADDR_W), .SLICE_AW(SLICE_AW), .NUM_CS(NUM_CS)) u_dec (
    .addr(addr), .mem_io(mem_io), .cs_n(cs_n), .hit(hit)
  );

  assign t1_hit = hit && (bus_phase == PH_ADDR);
  assign oe_n   = rd_n | ~hit;

  rbs_wait #(.WAIT_STATES(WAIT_STATES)) u_wait (
    .clk(clk), .rst_n(rst_n), .start(t1_hit), .rdy(rdy)
  );

endmodule

// File: rtl/rom_bank_sel_chk.sv
module rom_bank_sel_chk #(
  parameter int NUM_CS      = 8,
  parameter int WAIT_STATES = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_io,
  input logic              rd_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              oe_n,
  input logic              rdy,
  input logic              hit,
  input logic              t1_hit
);
  logic [7:0] lowrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lowrun <= '0;
    else if (!rdy)   lowrun <= (lowrun == 8'hFF) ? lowrun : lowrun + 8'd1;
    else             lowrun <= '0;
  end

  assert_one_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_io_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_io |-> (&cs_n));
  assert_oe_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> oe_n);
  assert_wait_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    t1_hit |=> !rdy);
  assert_wait_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lowrun <= 8'(WAIT_STATES));
  assert_wait_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(t1_hit));

endmodule

bind rom_bank_sel rom_bank_sel_chk #(.NUM_CS(NUM_CS), .WAIT_STATES(WAIT_STATES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_io(mem_io), .rd_n(rd_n), .cs_n(cs_n),
  .oe_n(oe_n), .rdy(rdy), .hit(hit), .t1_hit(t1_hit)
);

// File: tb/sim_rom_bank_sel.sv
module sim_rom_bank_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        mem_io = 1'b1;
  logic        rd_n = 1'b1;
  logic [1:0]  bus_phase = 2'b00;
  logic [7:0]  cs0_n, cs1_n;
  logic        oe0_n, oe1_n, rdy0, rdy1;
  int          nchk = 0;
  int          nbad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  rom_bank_sel u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .mem_io(mem_io), .rd_n(rd_n),
                   .bus_phase(bus_phase), .cs_n(cs0_n), .oe_n(oe0_n), .rdy(rdy0));
  rom_bank_sel #(.SLICE_AW(13)) u1 (.clk(clk), .rst_n(rst_n), .addr(addr), .mem_io(mem_io),
                   .rd_n(rd_n), .bus_phase(bus_phase), .cs_n(cs1_n), .oe_n(oe1_n), .rdy(rdy1));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s addr=%05h actual=%0h expected=%0h", req, addr, act, exp);
    end
  endtask

  // One bus cycle; both instances checked against arithmetic expectations.
  task automatic bus_cycle(input logic [19:0] a, input bit mem, input bit do_rd);
    bit hit0, hit1;
    int idx0, idx1, low0, low1;
    logic [7:0] e0, e1;
    hit0 = mem && (a >= 20'hF8000);
    hit1 = mem && (a >= 20'hF0000);
    idx0 = (int'(a) - 32'hF8000) / 4096;
    idx1 = (int'(a) - 32'hF0000) / 8192;
    e0 = hit0 ? ~(8'd1 << idx0) : 8'hFF;
    e1 = hit1 ? ~(8'd1 << idx1) : 8'hFF;
    low0 = 0; low1 = 0;
    @(negedge clk);
    addr = a; mem_io = mem; rd_n = 1'b1; bus_phase = 2'b01;
    #1;
    chk(cs0_n == e0, !mem ? "R4" : (hit0 ? "R2" : "R3"), 32'(cs0_n), 32'(e0));
    if (hit0) chk($countones(~cs0_n) == 1, "R1", 32'($countones(~cs0_n)), 1);
    chk(cs1_n == e1, "R9", 32'(cs1_n), 32'(e1));
    chk(oe0_n == 1'b1, "R5", 32'(oe0_n), 1);
    @(negedge clk);
    bus_phase = 2'b10; rd_n = !do_rd;
    #1;
    chk(oe0_n == !(hit0 && do_rd), "R5", 32'(oe0_n), 32'(!(hit0 && do_rd)));
    chk(oe1_n == !(hit1 && do_rd), "R5", 32'(oe1_n), 32'(!(hit1 && do_rd)));
    if (!rdy0) low0++;
    if (!rdy1) low1++;
    @(negedge clk);
    bus_phase = 2'b11;
    if (!rdy0) low0++;
    if (!rdy1) low1++;
    chk(rdy0 == 1'b1, "R6", 32'(rdy0), 1);
    @(negedge clk);
    bus_phase = 2'b00; rd_n = 1'b1;
    if (!rdy0) low0++;
    if (!rdy1) low1++;
    chk(low0 == int'(hit0), hit0 ? "R6" : "R7", 32'(low0), 32'(hit0));
    chk(low1 == int'(hit1), hit1 ? "R9" : "R7", 32'(low1), 32'(hit1));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy0 == 1'b1, "R8", 32'(rdy0), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy0 == 1'b1 && rdy1 == 1'b1, "R8", 32'({rdy0, rdy1}), 3);
    for (int k = 0; k < 8; k++) begin
      bus_cycle(20'hF8000 + 20'(k * 4096), 1'b1, 1'b1);
      bus_cycle(20'hF8FFF + 20'(k * 4096), 1'b1, 1'b0);
    end
    bus_cycle(20'hF7FFF, 1'b1, 1'b1);
    bus_cycle(20'hF0000, 1'b1, 1'b1);
    bus_cycle(20'hEFFFF, 1'b1, 1'b1);
    bus_cycle(20'h00000, 1'b1, 1'b1);
    bus_cycle(20'hF8000, 1'b0, 1'b1);
    bus_cycle(20'hFFFFF, 1'b0, 1'b1);
    for (int a = 0; a < 32'h100000; a += 32'h400) begin
      bus_cycle(20'(a + ((a >> 10) & 32'h3FF)), (a & 32'h1C00) != 32'h1C00, ((a >> 10) & 1) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule